// File: doc/BRIEF.md
# Flow Classifier Table Bring-Up Sequencer

This block is a bus master that runs once after reset to prepare a packet flow-classification table. A pulse on `start` captures a configuration: table memory size, match mode, status reporting mode, drop queue and the offset of the flexible match bytes. It then runs a fixed series of single-word transactions on a simple request/acknowledge register bus. These steps shrink receive packet buffer 0 by the table footprint and clear the other receive buffers. They load the two hash keys and rewrite every entry of the flexible-byte configuration array. Finally the block writes the control word and polls the control register until its init-done bit reports ready.

The block reports its progress on four status outputs: busy, done, configuration error and timeout. These values hold until the next accepted start. The register slave and the classifier are outside the block.

Top module: `fcls_init_seq`

## Requirements
- R1: After a start with valid configuration, the first transaction reads address 0x000 (receive buffer 0). The second writes back that value minus the table footprint: 0x10000, 0x20000 or 0x40000 bytes for size codes 0, 1 and 2.
- R2: Next come seven writes of zero to the buffer size registers 1 to 7 (address 0x000 + 4*k), in ascending order.
- R3: The bucket hash key is then written to 0x040 and the signature hash key to 0x044, with the parameter values, before any flexible-array or control write.
- R4: The control word written to 0x048 holds the size code plus one in bits [1:0], the value 10 in bits [19:16] and the value 4 in bits [23:20]. In perfect mode it also sets bit 4 and places the drop queue in bits [14:8]. In signature mode bit 4 and bits [14:8] are zero.
- R5: Report code 0 sets no report bit, code 1 sets bit 5 and code 2 sets bit 7.
- R6: The 64 flexible-byte entries are handled in ascending order, four 8-bit slices per register at 0x080 + 4*(e/4), with entry e in bits [8*(e%4)+7 : 8*(e%4)]. Each entry is a read of its register followed by a write that changes only its own slice to {0, offset_bytes/2 (5 bits), 2'b01}. The other three slices keep the value just read.
- R7: Size code 3, report code 3 or an odd byte offset is a configuration error. The block then sets done and the configuration-error flag, and issues no bus transaction.
- R8: After the control write, the block reads 0x048 at most POLL_MAX times. Between reads, the request line is low for exactly POLL_WAIT cycles. The first read with bit 3 set ends the run without error. If POLL_MAX reads all return bit 3 clear, the run ends with done and timeout set.
- R9: Out of reset the status is idle, with busy, done, error and timeout all low. Busy and done are never high together. Final status and bus silence hold until the next start. A start while busy has no effect, and neither does a configuration change while busy.
- R10: A request holds its address, direction and write data stable until the cycle in which acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle or done |
| cfg_alloc | input | 2 | Table size code: 0, 1 or 2 valid, 3 invalid |
| cfg_perfect | input | 1 | 1 for perfect match mode, 0 for signature mode |
| cfg_report | input | 2 | Status reporting code: 0 none, 1 on match, 2 always |
| cfg_drop_q | input | DQW | Drop queue index, used in perfect mode |
| cfg_flex_ofs | input | OFS_W | Flexible-byte offset in bytes, must be even |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte address of the register |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with acknowledge |
| bus_ack | input | 1 | One-cycle acknowledge that ends the transaction |
| sts_busy | output | 1 | Sequence running |
| sts_done | output | 1 | Sequence finished, held until next start |
| sts_cfg_err | output | 1 | Start was refused because of invalid configuration |
| sts_timeout | output | 1 | Init-done bit never seen within POLL_MAX reads |

## Verification
The bench sweeps every valid combination of size, mode and report code. It checks each buffer write against the value it preloaded minus the footprint, so a wrong shift in the footprint or a missed subtraction shows up as a wrong write-back. Each flexible-array register starts with a distinct pattern, and the bench replays every read-modify-write against its own model. A lane-select error would then overwrite a neighbouring slice, and a missing read would leave stale data. The poll is tested in four ways: ready on the first read, ready on a middle read, ready on exactly the last allowed read, and never ready. An off-by-one in the poll limit would then report a false timeout or one read too many, and a wrong wait count would change the idle gap between reads. Invalid codes, an odd offset, and a start with a bad configuration while busy must all produce an immediate error with no traffic, or be ignored, as the requirements state.

// File: rtl/fcls_pkg.sv
package fcls_pkg;

    // Register byte addresses
    localparam int unsigned ADDR_PB_BASE   = 32'h000;
    localparam int unsigned ADDR_BKT_KEY   = 32'h040;
    localparam int unsigned ADDR_SIG_KEY   = 32'h044;
    localparam int unsigned ADDR_CTRL      = 32'h048;
    localparam int unsigned ADDR_FLEX_BASE = 32'h080;
    localparam int unsigned ADDR_STEP      = 4;

    // Control word fields
    localparam int CTL_ALLOC_LSB   = 0;
    localparam int CTL_INIT_DONE   = 3;
    localparam int CTL_PERFECT     = 4;
    localparam int CTL_RPT_MATCH   = 5;
    localparam int CTL_RPT_ALWAYS  = 7;
    localparam int CTL_DROPQ_LSB   = 8;
    localparam int CTL_BKTLEN_LSB  = 16;
    localparam int CTL_FULLTHR_LSB = 20;

    localparam logic [3:0] BKT_LEN_VAL  = 4'd10;
    localparam logic [3:0] FULL_THR_VAL = 4'd4;

    typedef enum logic [1:0] {
        RPT_NONE   = 2'd0,
        RPT_MATCH  = 2'd1,
        RPT_ALWAYS = 2'd2,
        RPT_BAD    = 2'd3
    } report_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PB0_RD,
        S_PB0_WR,
        S_PBZ_WR,
        S_BKT_WR,
        S_SIG_WR,
        S_FLX_RD,
        S_FLX_WR,
        S_CTL_WR,
        S_POLL_RD,
        S_POLL_WAIT,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/fcls_cfg_decode.sv
module fcls_cfg_decode
    import fcls_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DQW     = 7,
    parameter int SLICE_W = 8,
    parameter int OFS_W   = 6
) (
    input  logic [1:0]         alloc,
    input  logic               perfect,
    input  logic [1:0]         report,
    input  logic [DQW-1:0]     drop_q,
    input  logic [OFS_W-1:0]   flex_ofs,
    output logic               valid,
    output logic [DW-1:0]      ctrl_word,
    output logic [DW-1:0]      footprint,
    output logic [SLICE_W-1:0] slice
);

    always_comb begin
        valid = (alloc != 2'd3) && (report != RPT_BAD) && !flex_ofs[0];

        ctrl_word = '0;
        ctrl_word[CTL_ALLOC_LSB +: 2]   = alloc + 2'd1;
        ctrl_word[CTL_PERFECT]          = perfect;
        ctrl_word[CTL_RPT_MATCH]        = (report == RPT_MATCH);
        ctrl_word[CTL_RPT_ALWAYS]       = (report == RPT_ALWAYS);
        ctrl_word[CTL_BKTLEN_LSB +: 4]  = BKT_LEN_VAL;
        ctrl_word[CTL_FULLTHR_LSB +: 4] = FULL_THR_VAL;
        if (perfect) begin
            ctrl_word[CTL_DROPQ_LSB +: DQW] = drop_q;
        end

        footprint = DW'(32'h0001_0000) << alloc;

        slice = '0;
        slice[1:0] = 2'b01;
        slice[2 +: OFS_W-1] = flex_ofs[OFS_W-1:1];
    end

endmodule

// File: rtl/fcls_slice_merge.sv
module fcls_slice_merge #(
    parameter int DW      = 32,
    parameter int SLICE_W = 8,
    parameter int LANES   = DW / SLICE_W,
    parameter int SEL_W   = $clog2(LANES)
) (
    input  logic [DW-1:0]      word_in,
    input  logic [SLICE_W-1:0] slice,
    input  logic [SEL_W-1:0]   sel,
    output logic [DW-1:0]      word_out
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign word_out[l*SLICE_W +: SLICE_W] =
            (sel == SEL_W'(l)) ? slice : word_in[l*SLICE_W +: SLICE_W];
    end

endmodule

// File: rtl/fcls_wait_timer.sv
module fcls_wait_timer #(
    parameter int unsigned WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = $clog2(WAIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WAIT - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R8: the wait count never starts above the programmed interval
    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WAIT - 1));

endmodule

// File: rtl/fcls_init_seq.sv
module fcls_init_seq
    import fcls_pkg::*;
#(
    parameter int          DW           = 32,
    parameter int          AW           = 12,
    parameter int          DQW          = 7,
    parameter int          OFS_W        = 6,
    parameter int          NUM_PB       = 8,
    parameter int          FLEX_ENTRIES = 64,
    parameter int          ENT_PER_REG  = 4,
    parameter int          POLL_MAX     = 10,
    parameter int unsigned POLL_WAIT    = 250000,
    parameter logic [31:0] BKT_KEY      = 32'h6C2B_91E5,
    parameter logic [31:0] SIG_KEY      = 32'h0F4A_D37B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       cfg_alloc,
    input  logic             cfg_perfect,
    input  logic [1:0]       cfg_report,
    input  logic [DQW-1:0]   cfg_drop_q,
    input  logic [OFS_W-1:0] cfg_flex_ofs,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ack,
    output logic             sts_busy,
    output logic             sts_done,
    output logic             sts_cfg_err,
    output logic             sts_timeout
);

    localparam int SLICE_W = DW / ENT_PER_REG;
    localparam int LANE_W  = $clog2(ENT_PER_REG);
    localparam int ENT_W   = $clog2(FLEX_ENTRIES);
    localparam int PB_W    = $clog2(NUM_PB);
    localparam int PC_W    = $clog2(POLL_MAX + 1);

    typedef struct packed {
        seq_state_e         state;
        logic [PB_W-1:0]    pb_idx;
        logic [ENT_W-1:0]   ent_idx;
        logic [PC_W-1:0]    polls;
        logic [DW-1:0]      data;
        logic [DW-1:0]      ctrl;
        logic [DW-1:0]      fp;
        logic [SLICE_W-1:0] slice;
        logic               done;
        logic               cfg_err;
        logic               timeout;
    } seq_regs_t;

    seq_regs_t d, q;

    logic               cfg_valid;
    logic [DW-1:0]      dec_ctrl;
    logic [DW-1:0]      dec_fp;
    logic [SLICE_W-1:0] dec_slice;
    logic [DW-1:0]      merged;
    logic               tmr_load;
    logic               tmr_expired;
    logic [PC_W-1:0]    polls_inc;

    fcls_cfg_decode #(
        .DW(DW), .DQW(DQW), .SLICE_W(SLICE_W), .OFS_W(OFS_W)
    ) dec_i (
        .alloc     (cfg_alloc),
        .perfect   (cfg_perfect),
        .report    (cfg_report),
        .drop_q    (cfg_drop_q),
        .flex_ofs  (cfg_flex_ofs),
        .valid     (cfg_valid),
        .ctrl_word (dec_ctrl),
        .footprint (dec_fp),
        .slice     (dec_slice)
    );

    fcls_slice_merge #(
        .DW(DW), .SLICE_W(SLICE_W), .LANES(ENT_PER_REG), .SEL_W(LANE_W)
    ) merge_i (
        .word_in  (bus_rdata),
        .slice    (q.slice),
        .sel      (q.ent_idx[LANE_W-1:0]),
        .word_out (merged)
    );

    fcls_wait_timer #(
        .WAIT(POLL_WAIT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    assign polls_inc = q.polls + 1'b1;

    // Next-state logic
    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        unique case (q.state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    d.done    = !cfg_valid;
                    d.cfg_err = !cfg_valid;
                    d.timeout = 1'b0;
                    d.ctrl    = dec_ctrl;
                    d.fp      = dec_fp;
                    d.slice   = dec_slice;
                    d.state   = cfg_valid ? S_PB0_RD : S_DONE;
                end
            end
            S_PB0_RD: begin
                if (bus_ack) begin
                    d.data  = bus_rdata - q.fp;
                    d.state = S_PB0_WR;
                end
            end
            S_PB0_WR: begin
                if (bus_ack) begin
                    d.pb_idx = PB_W'(1);
                    d.state  = S_PBZ_WR;
                end
            end
            S_PBZ_WR: begin
                if (bus_ack) begin
                    if (q.pb_idx == PB_W'(NUM_PB - 1)) begin
                        d.state = S_BKT_WR;
                    end else begin
                        d.pb_idx = q.pb_idx + 1'b1;
                    end
                end
            end
            S_BKT_WR: begin
                if (bus_ack) begin
                    d.state = S_SIG_WR;
                end
            end
            S_SIG_WR: begin
                if (bus_ack) begin
                    d.ent_idx = '0;
                    d.state   = S_FLX_RD;
                end
            end
            S_FLX_RD: begin
                if (bus_ack) begin
                    d.data  = merged;
                    d.state = S_FLX_WR;
                end
            end
            S_FLX_WR: begin
                if (bus_ack) begin
                    if (q.ent_idx == ENT_W'(FLEX_ENTRIES - 1)) begin
                        d.state = S_CTL_WR;
                    end else begin
                        d.ent_idx = q.ent_idx + 1'b1;
                        d.state   = S_FLX_RD;
                    end
                end
            end
            S_CTL_WR: begin
                if (bus_ack) begin
                    d.polls = '0;
                    d.state = S_POLL_RD;
                end
            end
            S_POLL_RD: begin
                if (bus_ack) begin
                    d.polls = polls_inc;
                    if (bus_rdata[CTL_INIT_DONE]) begin
                        d.done  = 1'b1;
                        d.state = S_DONE;
                    end else if (polls_inc == PC_W'(POLL_MAX)) begin
                        d.done    = 1'b1;
                        d.timeout = 1'b1;
                        d.state   = S_DONE;
                    end else begin
                        tmr_load = 1'b1;
                        d.state  = S_POLL_WAIT;
                    end
                end
            end
            S_POLL_WAIT: begin
                if (tmr_expired) begin
                    d.state = S_POLL_RD;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Bus drive, decoded from registered state only
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (q.state)
            S_PB0_RD: begin
                bus_req  = 1'b1;
                bus_addr = AW'(ADDR_PB_BASE);
            end
            S_PB0_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(ADDR_PB_BASE);
                bus_wdata = q.data;
            end
            S_PBZ_WR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = AW'(ADDR_PB_BASE + ADDR_STEP * q.pb_idx);
            end
            S_BKT_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(ADDR_BKT_KEY);
                bus_wdata = DW'(BKT_KEY);
            end
            S_SIG_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(ADDR_SIG_KEY);
                bus_wdata = DW'(SIG_KEY);
            end
            S_FLX_RD: begin
                bus_req  = 1'b1;
                bus_addr = AW'(ADDR_FLEX_BASE + ADDR_STEP * (q.ent_idx >> LANE_W));
            end
            S_FLX_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(ADDR_FLEX_BASE + ADDR_STEP * (q.ent_idx >> LANE_W));
                bus_wdata = q.data;
            end
            S_CTL_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = AW'(ADDR_CTRL);
                bus_wdata = q.ctrl;
            end
            S_POLL_RD: begin
                bus_req  = 1'b1;
                bus_addr = AW'(ADDR_CTRL);
            end
            default: ;
        endcase
    end

    assign sts_busy    = (q.state != S_IDLE) && (q.state != S_DONE);
    assign sts_done    = q.done;
    assign sts_cfg_err = q.cfg_err;
    assign sts_timeout = q.timeout;

    // R10: an unacknowledged request stays put
    a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R9: busy and done exclusive
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_busy && sts_done));

    // R9: final status holds without a start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sts_done && !start |=> sts_done);

    // R7: a refused start produces no traffic
    a_r7_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        sts_cfg_err |-> !bus_req);

    // R8: poll count bounded, timeout only as a finished run
    a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls <= PC_W'(POLL_MAX));

    a_r8_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
        sts_timeout |-> sts_done && !sts_cfg_err);

endmodule

// File: tb/fcls_init_seq_tb.sv
module fcls_init_seq_tb_top;

    localparam int POLL_MAX  = 5;
    localparam int POLL_WAIT = 3;
    localparam logic [31:0] BKT_KEY = 32'h6C2B_91E5;
    localparam logic [31:0] SIG_KEY = 32'h0F4A_D37B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_alloc = '0;
    logic        cfg_perfect = 1'b0;
    logic [1:0]  cfg_report = '0;
    logic [6:0]  cfg_drop_q = '0;
    logic [5:0]  cfg_flex_ofs = '0;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        sts_busy, sts_done, sts_cfg_err, sts_timeout;

    always #2 clk = ~clk;

    fcls_init_seq #(
        .POLL_MAX(POLL_MAX), .POLL_WAIT(POLL_WAIT), .BKT_KEY(BKT_KEY), .SIG_KEY(SIG_KEY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_alloc(cfg_alloc), .cfg_perfect(cfg_perfect), .cfg_report(cfg_report),
        .cfg_drop_q(cfg_drop_q), .cfg_flex_ofs(cfg_flex_ofs),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .sts_busy(sts_busy), .sts_done(sts_done), .sts_cfg_err(sts_cfg_err),
        .sts_timeout(sts_timeout)
    );

    // ---------------- register slave model with transaction log
    logic [31:0] mem [64];
    logic [11:0] log_addr [256];
    logic        log_we   [256];
    logic [31:0] log_data [256];
    int          log_idle [256];
    int          log_n;
    int          idle_run;
    int          ctl_reads;
    int          done_after;
    int          seed;
    logic        tb_clear = 1'b0;
    logic        ack_q;
    logic [31:0] rd_q;
    logic [31:0] rd_val;

    assign bus_ack   = ack_q;
    assign bus_rdata = rd_q;

    function automatic logic [31:0] init_val(input int i, input int s);
        return 32'h5A3C_0000 ^ (32'(i) << 8) ^ (32'(s) * 32'h0101_0101) ^ 32'(i * 7);
    endfunction

    function automatic logic [31:0] pb0_init(input int s);
        return 32'h0010_0000 + 32'(s) * 32'h10;
    endfunction

    always_comb begin
        rd_val = mem[bus_addr[7:2]];
        if (bus_addr == 12'h048 && done_after != 0 && (ctl_reads + 1) >= done_after)
            rd_val = rd_val | 32'h8;
    end

    always @(posedge clk) begin
        if (!rst_n || tb_clear) begin
            ack_q     <= 1'b0;
            log_n     <= 0;
            idle_run  <= 0;
            ctl_reads <= 0;
            rd_q      <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= (i == 0) ? pb0_init(seed) : init_val(i, seed);
        end else begin
            ack_q <= 1'b0;
            if (!bus_req) idle_run <= idle_run + 1;
            if (bus_req && !ack_q) begin
                ack_q    <= 1'b1;
                idle_run <= 0;
                if (log_n < 256) begin
                    log_addr[log_n] <= bus_addr;
                    log_we[log_n]   <= bus_we;
                    log_data[log_n] <= bus_we ? bus_wdata : rd_val;
                    log_idle[log_n] <= idle_run;
                    log_n <= log_n + 1;
                end
                if (bus_we) begin
                    mem[bus_addr[7:2]] <= bus_wdata;
                end else begin
                    rd_q <= rd_val;
                    if (bus_addr == 12'h048) ctl_reads <= ctl_reads + 1;
                end
            end
        end
    end

    // ---------------- checking
    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl(input int a, input bit p, input int r, input logic [6:0] dq);
        logic [31:0] w = '0;
        w[1:0]   = 2'(a + 1);
        w[4]     = p;
        w[5]     = (r == 1);
        w[7]     = (r == 2);
        w[19:16] = 4'd10;
        w[23:20] = 4'd4;
        if (p) w[14:8] = dq;
        return w;
    endfunction

    task automatic run_case(input int a, input bit p, input int r, input logic [6:0] dq,
                            input logic [5:0] ofs, input int dn, input int s, input bit interfere);
        bit          valid;
        int          np;
        bit          exp_to;
        bit          ok;
        logic [31:0] fm [16];
        logic [31:0] e_val, a_val;
        logic [7:0]  slc;
        int          wait_n;
        int          n_end;
        valid = (a != 3) && (r != 3) && !ofs[0];
        @(negedge clk);
        seed = s; done_after = dn;
        cfg_alloc = 2'(a); cfg_perfect = p; cfg_report = 2'(r); cfg_drop_q = dq; cfg_flex_ofs = ofs;
        tb_clear = 1'b1;
        @(negedge clk);
        tb_clear = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (interfere) begin
            repeat (40) @(negedge clk);
            cfg_alloc = 2'd3; cfg_report = 2'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (!sts_done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(sts_done, "R9 run finishes", 32'(sts_done), 32'h1);

        if (!valid) begin
            chk(sts_cfg_err && !sts_timeout && log_n == 0, "R7 config error, no traffic",
                {sts_cfg_err, sts_timeout, 30'(log_n)}, 32'h8000_0000);
        end else begin
            np     = (dn == 0 || dn > POLL_MAX) ? POLL_MAX : dn;
            exp_to = (dn == 0 || dn > POLL_MAX);
            chk(!sts_cfg_err && !sts_busy, "R9 clean status", {sts_cfg_err, sts_busy}, 32'h0);
            chk(sts_timeout == exp_to, "R8 timeout flag", 32'(sts_timeout), 32'(exp_to));
            chk(log_n == 140 + np, interfere ? "R9 start while busy ignored" : "R8 transaction count",
                32'(log_n), 32'(140 + np));
            // R1
            ok = log_addr[0] == 12'h000 && !log_we[0] && log_addr[1] == 12'h000 && log_we[1] &&
                 log_data[1] == pb0_init(s) - (32'h10000 << a);
            chk(ok, "R1 buffer 0 resize", log_data[1], pb0_init(s) - (32'h10000 << a));
            // R2
            ok = 1'b1;
            for (int k = 1; k < 8; k++)
                if (log_addr[k+1] != 12'(4*k) || !log_we[k+1] || log_data[k+1] != 0) ok = 1'b0;
            chk(ok, "R2 buffers 1..7 zeroed", {log_addr[2], 20'(log_data[2])}, 32'h0040_0000);
            // R3
            ok = log_addr[9] == 12'h040 && log_we[9] && log_data[9] == BKT_KEY &&
                 log_addr[10] == 12'h044 && log_we[10] && log_data[10] == SIG_KEY;
            chk(ok, "R3 hash keys", log_data[10], SIG_KEY);
            // R6
            for (int j = 0; j < 16; j++) fm[j] = init_val(32 + j, s);
            slc = {1'b0, ofs[5:1], 2'b01};
            ok = 1'b1; e_val = '0; a_val = '0;
            for (int e = 0; e < 64; e++) begin
                logic [31:0] nw;
                nw = fm[e/4];
                nw[8*(e%4) +: 8] = slc;
                if (log_addr[11+2*e] != 12'(32'h80 + 4*(e/4)) || log_we[11+2*e] ||
                    log_addr[12+2*e] != 12'(32'h80 + 4*(e/4)) || !log_we[12+2*e] ||
                    log_data[12+2*e] != nw) begin
                    if (ok) begin e_val = nw; a_val = log_data[12+2*e]; end
                    ok = 1'b0;
                end
                fm[e/4] = nw;
            end
            chk(ok, "R6 flex array read-modify-write", a_val, e_val);
            // R4 / R5
            ok = log_addr[139] == 12'h048 && log_we[139];
            e_val = exp_ctrl(a, p, r, dq);
            chk(ok && log_data[139][23:8] == e_val[23:8] && log_data[139][4] == e_val[4] &&
                log_data[139][1:0] == e_val[1:0], "R4 control word", log_data[139], e_val);
            chk(log_data[139][7:5] == e_val[7:5], "R5 report bits",
                32'(log_data[139][7:5]), 32'(e_val[7:5]));
            // R8
            ok = 1'b1;
            for (int k = 0; k < np; k++) begin
                if (log_addr[140+k] != 12'h048 || log_we[140+k]) ok = 1'b0;
                if (k > 0 && log_idle[140+k] != POLL_WAIT) ok = 1'b0;
            end
            chk(ok, "R8 poll reads and wait gap", 32'(log_idle[140 + np - 1]),
                32'(np > 1 ? POLL_WAIT : 0));
        end
        // R9 hold after finish
        n_end = log_n;
        repeat (12) @(negedge clk);
        chk(sts_done && !sts_busy && log_n == n_end && !bus_req, "R9 status held, bus idle",
            {sts_done, sts_busy, 30'(log_n)}, {2'b10, 30'(n_end)});
    endtask

    initial begin
        int k;
        seed = 0; done_after = 0;
        repeat (3) @(negedge clk);
        chk(!sts_busy && !sts_done && !sts_cfg_err && !sts_timeout && !bus_req, "R9 reset state",
            {sts_busy, sts_done, sts_cfg_err, sts_timeout, bus_req}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sts_busy && !sts_done && !bus_req, "R9 idle after reset",
            {sts_busy, sts_done, bus_req}, 32'h0);

        k = 0;
        for (int a = 0; a < 3; a++)
            for (int p = 0; p < 2; p++)
                for (int r = 0; r < 3; r++) begin
                    run_case(a, p[0], r, 7'(k*5 + 3), 6'((k*4) % 64), (k % 4) + 1, k, k == 7);
                    k++;
                end
        run_case(1, 1'b1, 2, 7'h7F, 6'd62, POLL_MAX, 40, 1'b0);   // ready on last poll, max offset
        run_case(2, 1'b0, 0, 7'h11, 6'd12, 0, 41, 1'b0);          // never ready: timeout
        run_case(3, 1'b0, 0, 7'h01, 6'd12, 1, 42, 1'b0);          // bad size code
        run_case(0, 1'b1, 1, 7'h22, 6'd12, 2, 43, 1'b0);          // recovers from error
        run_case(0, 1'b0, 3, 7'h01, 6'd12, 1, 44, 1'b0);          // bad report code
        run_case(1, 1'b0, 1, 7'h01, 6'd13, 1, 45, 1'b0);          // odd offset
        run_case(2, 1'b1, 0, 7'h00, 6'd0, 3, 46, 1'b0);           // zero offset

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule